// File: doc/BRIEF.md
# Serial FPGA Configuration Master

This block loads a daisy chain of FPGAs that wait as serial configuration slaves. It reads one combined configuration image from a byte-wide parallel flash and sends it to the chain one bit at a time. The block drives the serial configuration clock, the data line and the active-low clear pulse that restarts configuration in every FPGA of the chain. It watches two status lines from the chain. The ready line goes high once the slaves can take data. The finished line goes high once the last FPGA in the chain has taken its configuration.

A run starts in two cases: automatically on the first cycle after reset, or when the board management controller sends a one-cycle command pulse. Both triggers are honoured only while the enable bit of a 4-bit switch input is set. The other three switch bits select which 16 MiB region of the 64 MiB flash holds the image. The default region is the top quarter. A lower region can hold a fallback image in case the default one is corrupted.

Streaming stops as soon as the finished line rises, so a chain with fewer FPGAs than the image covers still configures correctly. The rest of the image is never read. The run ends with a success flag, or with an error flag if the ready line drops during the run or the region is used up before the chain finishes.

Top module: `serial_cfg_master`

## Requirements
- R1: On the first clock cycle after reset is released, a configuration run starts if switch bit 0 (enable) is 1.
- R2: When idle, a one-cycle `mgmt_start` pulse starts a run if switch bit 0 is 1. While bit 0 is 0, neither `mgmt_start` nor the reset release starts a run: `cfg_clear_n` stays 1 and no flash read is issued.
- R3: Switch bits 3..1 form a revision value v that is sampled at the start of the run. The image base is 48 MiB (0x3000000) for v = 0. For any other v the base is (3 - (v mod 4)) x 16 MiB.
- R4: Each run first drives `cfg_clear_n` low for exactly PROG_CYC (default 16) clock cycles and then releases it. No configuration clock edge and no flash read occur until `cfg_ready` is high.
- R5: Image bytes are read from consecutive flash addresses starting at the base. Each byte is sent most-significant bit first, one bit per rising edge of `cfg_clk_o`. `cfg_data` is stable across each rising edge.
- R6: At the first byte boundary where `cfg_finished` is high, the block stops reading flash. It then gives exactly TAIL_CLKS (default 8) more rising edges, returns `cfg_clk_o` to 0, sets `cfg_ok` and goes idle. No further image bytes are sent.
- R7: If `cfg_ready` goes low after it was seen high during a run, the block sets `cfg_err` and goes idle.
- R8: If WIN_BYTES bytes have been sent and `cfg_finished` is still low, the block sets `cfg_err` and goes idle without reading past the region.
- R9: While idle, `cfg_clk_o` is 0 and `cfg_clear_n` is 1. `cfg_ok` and `cfg_err` are never both 1, both are 0 after reset, and both are cleared when a run starts.
- R10: Each flash read is a one-cycle `flash_rd` pulse with `flash_addr` valid. The next read is issued only after `flash_valid` has returned the previous byte. Every address lies inside the selected region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_cfg | input | 4 | Bit 0 enable, bits 3..1 revision select |
| mgmt_start | input | 1 | One-cycle start command from the management controller |
| flash_addr | output | 26 | Byte address of the flash read |
| flash_rd | output | 1 | One-cycle read strobe |
| flash_data | input | 8 | Byte returned by the flash |
| flash_valid | input | 1 | `flash_data` is valid this cycle |
| cfg_ready | input | 1 | Chain ready for data (high = ready) |
| cfg_finished | input | 1 | Chain fully configured |
| cfg_clk_o | output | 1 | Serial configuration clock |
| cfg_clear_n | output | 1 | Active-low clear pulse to all FPGAs |
| cfg_data | output | 1 | Serial configuration data |
| busy | output | 1 | A run is in progress |
| cfg_ok | output | 1 | Last run finished successfully |
| cfg_err | output | 1 | Last run failed |

## Verification
The embedded properties are checked on every cycle. They cover the idle levels of the clock and clear lines, the exclusive success and error flags, and data stability across each rising clock edge. They also cover single-cycle read strobes with in-region addresses, the absence of clock edges and reads while the clear pulse is low or the chain is not ready, and the fact that a disabled switch keeps the block idle. Other behaviour can only be shown by the bench's scenarios with its chain and flash models. That covers the exact byte contents and bit order, the region chosen by each revision value, the count of bytes sent before the finished line rises, the eight trailing clocks, the exact length of the clear pulse, and the error paths for a dropped ready line and a used-up region.

// File: rtl/serial_cfg_master.sv
module serial_cfg_master #(
  parameter int ADDR_W    = 26,
  parameter int REGION_W  = 24,
  parameter int WIN_BYTES = 1 << 24,
  parameter int PROG_CYC  = 16,
  parameter int TAIL_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        sw_cfg,
  input  logic              mgmt_start,
  output logic [ADDR_W-1:0] flash_addr,
  output logic              flash_rd,
  input  logic [7:0]        flash_data,
  input  logic              flash_valid,
  input  logic              cfg_ready,
  input  logic              cfg_finished,
  output logic              cfg_clk_o,
  output logic              cfg_clear_n,
  output logic              cfg_data,
  output logic              busy,
  output logic              cfg_ok,
  output logic              cfg_err
);

  localparam int SEL_W = ADDR_W - REGION_W;
  localparam int CNT_W = REGION_W + 1;
  localparam int PW    = $clog2(PROG_CYC + 1);
  localparam int TW    = $clog2(TAIL_CLKS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CLEAR, S_WREADY, S_NEXT, S_FETCH, S_SHIFT, S_TAIL
  } state_t;

  state_t           state;
  logic             pwr_pend;
  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    pcnt;
  logic [TW-1:0]    tcnt;
  logic [2:0]       bidx;
  logic [6:0]       sreg;
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;
  logic [2:0]       rev;
  logic             go;

  assign rev   = sw_cfg[3:1];
  assign sel_d = (rev == 3'd0) ? {SEL_W{1'b1}} : SEL_W'(~rev[1:0]);
  assign go    = (state == S_IDLE) && sw_cfg[0] && (pwr_pend || mgmt_start);
  assign busy  = (state != S_IDLE);
  assign flash_addr = {sel_q, cnt[REGION_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      pwr_pend    <= 1'b1;
      cnt         <= '0;
      pcnt        <= '0;
      tcnt        <= '0;
      bidx        <= '0;
      sreg        <= '0;
      sel_q       <= '0;
      flash_rd    <= 1'b0;
      cfg_clk_o   <= 1'b0;
      cfg_clear_n <= 1'b1;
      cfg_data    <= 1'b0;
      cfg_ok      <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      pwr_pend <= 1'b0;
      flash_rd <= 1'b0;
      case (state)
        S_IDLE: begin
          if (go) begin
            state       <= S_CLEAR;
            cfg_clear_n <= 1'b0;
            pcnt        <= '0;
            cnt         <= '0;
            cfg_ok      <= 1'b0;
            cfg_err     <= 1'b0;
            sel_q       <= sel_d;
          end
        end
        S_CLEAR: begin
          pcnt <= pcnt + 1'b1;
          if (pcnt == PW'(PROG_CYC - 1)) begin
            cfg_clear_n <= 1'b1;
            state       <= S_WREADY;
          end
        end
        S_WREADY: begin
          if (cfg_ready) state <= S_NEXT;
        end
        S_NEXT: begin
          if (!cfg_ready) begin
            cfg_err <= 1'b1;
            state   <= S_IDLE;
          end else if (cfg_finished) begin
            tcnt  <= '0;
            state <= S_TAIL;
          end else if (cnt == CNT_W'(WIN_BYTES)) begin
            cfg_err <= 1'b1;
            state   <= S_IDLE;
          end else begin
            flash_rd <= 1'b1;
            state    <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (!cfg_ready) begin
            cfg_err <= 1'b1;
            state   <= S_IDLE;
          end else if (flash_valid) begin
            sreg     <= flash_data[6:0];
            cfg_data <= flash_data[7];
            bidx     <= '0;
            cnt      <= cnt + 1'b1;
            state    <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (!cfg_ready) begin
            cfg_clk_o <= 1'b0;
            cfg_err   <= 1'b1;
            state     <= S_IDLE;
          end else if (!cfg_clk_o) begin
            cfg_clk_o <= 1'b1;
          end else begin
            cfg_clk_o <= 1'b0;
            if (bidx == 3'd7) begin
              state <= S_NEXT;
            end else begin
              bidx     <= bidx + 1'b1;
              cfg_data <= sreg[6];
              sreg     <= {sreg[5:0], 1'b0};
            end
          end
        end
        S_TAIL: begin
          if (!cfg_clk_o) begin
            cfg_clk_o <= 1'b1;
          end else begin
            cfg_clk_o <= 1'b0;
            tcnt      <= tcnt + 1'b1;
            if (tcnt == TW'(TAIL_CLKS - 1)) begin
              cfg_ok <= 1'b1;
              state  <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9
  ok_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_ok && cfg_err));

  // R9
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cfg_clk_o && cfg_clear_n));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk_o) |-> $stable(cfg_data));

  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_rd |=> !flash_rd);

  // R10
  rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_rd |-> ({1'b0, flash_addr[REGION_W-1:0]} < CNT_W'(WIN_BYTES)));

  // R4
  clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_clear_n |-> (!cfg_clk_o && !flash_rd));

  // R4
  wait_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WREADY && !cfg_ready) |=> (!cfg_clk_o && !flash_rd));

  // R2
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sw_cfg[0]) |=> !busy);

endmodule

// File: tb/serial_cfg_master_tb.sv
module serial_cfg_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] sw_cfg = 4'b0;
  logic mgmt_start = 1'b0;
  logic [25:0] flash_addr;
  logic flash_rd;
  logic [7:0] fl_data = 8'h0;
  logic fl_valid = 1'b0;
  logic s_ready = 1'b0;
  logic s_done = 1'b0;
  logic cfg_clk_o, cfg_clear_n, cfg_data, busy, cfg_ok, cfg_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_master #(.WIN_BYTES(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_cfg(sw_cfg), .mgmt_start(mgmt_start),
    .flash_addr(flash_addr), .flash_rd(flash_rd), .flash_data(fl_data),
    .flash_valid(fl_valid), .cfg_ready(s_ready), .cfg_finished(s_done),
    .cfg_clk_o(cfg_clk_o), .cfg_clear_n(cfg_clear_n), .cfg_data(cfg_data),
    .busy(busy), .cfg_ok(cfg_ok), .cfg_err(cfg_err));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  function automatic logic [7:0] fmem(input logic [25:0] a);
    return (a[7:0] * 8'd37) ^ {6'b0, a[25:24]} ^ 8'h5A ^ a[15:8];
  endfunction

  function automatic logic [25:0] fbase(input logic [2:0] r);
    logic [1:0] s;
    s = (r == 3'd0) ? 2'd3 : 2'(3 - (r % 4));
    return {s, 24'h0};
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // chain and flash models
  logic clr = 1'b0;
  int n_target = 0, kill_at = 0;
  logic [25:0] exp_base = 26'h0;
  int idly = 0, s_bits = 0, s_rx = 0, s_bad = 0, s_post = 0, s_early = 0;
  int proglow = 0, rd_cnt = 0, fl_wait = 0;
  logic [25:0] first_addr = 26'h0, last_addr = 26'h0, fl_addr = 26'h0;
  logic cclk_d = 1'b0;
  logic [7:0] s_sh = 8'h0;

  always @(posedge clk) begin
    cclk_d <= cfg_clk_o;
    if (clr) begin
      s_bits <= 0; s_rx <= 0; s_bad <= 0; s_post <= 0; s_early <= 0;
      proglow <= 0;
    end else if (!cfg_clear_n) begin
      s_ready <= 1'b0; s_done <= 1'b0; idly <= 0; proglow <= proglow + 1;
    end else begin
      if (kill_at > 0 && s_rx >= kill_at) s_ready <= 1'b0;
      else if (idly < 4) idly <= idly + 1;
      else s_ready <= 1'b1;
      if (cfg_clk_o && !cclk_d) begin
        if (!s_ready) s_early <= s_early + 1;
        if (s_done) s_post <= s_post + 1;
        else begin
          s_sh <= {s_sh[6:0], cfg_data};
          s_bits <= s_bits + 1;
          if (s_bits % 8 == 7) begin
            if ({s_sh[6:0], cfg_data} != fmem(exp_base + 26'(s_rx))) s_bad <= s_bad + 1;
            s_rx <= s_rx + 1;
            if (n_target != 0 && s_rx + 1 == n_target) s_done <= 1'b1;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    fl_valid <= 1'b0;
    if (clr) begin
      rd_cnt <= 0; fl_wait <= 0;
    end else if (flash_rd) begin
      fl_addr <= flash_addr;
      fl_wait <= 1 + int'($urandom % 3);
      if (rd_cnt == 0) first_addr <= flash_addr;
      last_addr <= flash_addr;
      rd_cnt <= rd_cnt + 1;
    end else if (fl_wait == 1) begin
      fl_valid <= 1'b1;
      fl_data <= fmem(fl_addr);
      fl_wait <= 0;
    end else if (fl_wait > 1) begin
      fl_wait <= fl_wait - 1;
    end
  end

  task automatic clear_models();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int t = 0;
    @(negedge clk);
    while (busy && t < 20000) begin @(negedge clk); t++; end
    chk({req, " run completes"}, busy, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_ok(input int n);
    chk("R6 ok flag", cfg_ok, 1);
    chk("R9 err clear", cfg_err, 0);
    chk("R6 bytes sent", s_rx, n);
    chk("R5 byte contents msb first", s_bad, 0);
    chk("R6 trailing clocks", s_post, 8);
    chk("R4 clear pulse length", proglow, 16);
    chk("R4 no clock before ready", s_early, 0);
    chk("R3 first address", first_addr, exp_base);
    chk("R5 last address", last_addr, exp_base + 26'(n - 1));
    chk("R10 read count", rd_cnt, n);
    chk("R9 clock idle low", cfg_clk_o, 0);
  endtask

  task automatic run_cmd(input logic [2:0] rev, input int n, input int kill);
    sw_cfg = {rev, 1'b1};
    n_target = n; kill_at = kill;
    exp_base = fbase(rev);
    clear_models();
    mgmt_start = 1'b1;
    @(negedge clk); mgmt_start = 1'b0;
    wait_idle("R2");
  endtask

  initial begin
    void'($urandom(32'd2024));
    // power-up start, revision 0
    sw_cfg = 4'b0001; n_target = 5; exp_base = fbase(3'd0);
    clr = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 reset ok", cfg_ok, 0);
    chk("R9 reset err", cfg_err, 0);
    chk("R9 reset clear line", cfg_clear_n, 1);
    clr = 1'b0; rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 power-up start", busy, 1);
    wait_idle("R1");
    check_ok(5);
    chk("R3 default base 48MiB", first_addr, 26'h3000000);

    // disabled: command ignored
    sw_cfg = 4'b0110; clear_models();
    mgmt_start = 1'b1; @(negedge clk); mgmt_start = 1'b0;
    repeat (40) @(negedge clk);
    chk("R2 disabled busy", busy, 0);
    chk("R2 disabled no clear pulse", proglow, 0);
    chk("R2 disabled no read", rd_cnt, 0);
    chk("R2 disabled flags kept", cfg_ok, 1);

    // disabled: power-up ignored
    rst_n = 1'b0; sw_cfg = 4'b1110;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 disabled power-up", busy, 0);
    chk("R1 disabled power-up no pulse", proglow, 0);

    // directed corners
    run_cmd(3'd1, 1, 0);
    check_ok(1);
    chk("R3 backup base 32MiB", first_addr, 26'h2000000);
    run_cmd(3'd3, WIN, 0);
    check_ok(WIN);
    run_cmd(3'd2, 0, 0);
    chk("R8 window err", cfg_err, 1);
    chk("R8 window ok clear", cfg_ok, 0);
    chk("R8 window bytes", s_rx, WIN);
    chk("R8 window reads", rd_cnt, WIN);
    chk("R8 last address", last_addr, fbase(3'd2) + 26'(WIN - 1));
    run_cmd(3'd0, 10, 3);
    chk("R7 ready drop err", cfg_err, 1);
    chk("R7 ready drop ok clear", cfg_ok, 0);
    chk("R7 ready drop stops stream", (s_rx <= 4) ? 1 : 0, 1);
    run_cmd(3'd5, 3, 0);
    check_ok(3);
    chk("R9 ok after err run", cfg_err, 0);

    // random runs
    for (int i = 0; i < 10; i++) begin
      logic [2:0] r;
      int n;
      r = 3'($urandom % 8);
      n = 1 + int'($urandom % WIN);
      run_cmd(r, n, 0);
      check_ok(n);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule